// File: doc/BRIEF.md
# Daisy-Chain Switch Shift Interface

This block is the chained-operation front end of a serial-controlled octal switch. It sits on a four-wire serial slave port made up of an active-low frame select, a serial clock, serial data in and serial data out. In its power-up address mode, every frame returns a fixed alignment byte (0x25) and then zeros on the serial output. The block watches each address-mode frame for the 16-bit entry word 0x2500. That word arrives while the device is already returning 0x25 followed by zeros. The next device in a chain therefore receives the same entry word within the same frame, and a whole string of devices changes mode together.

Once in chain mode, the block behaves as an 8-bit delay line. Each bit taken from the serial input reappears on the serial output eight serial clocks later, ready for the next device. When the frame select rises, the eight most recently received bits are loaded into the switch data register, and that register drives the eight switch enables directly. The delay line keeps its contents from one frame to the next. Only the hardware reset input takes the block back to address mode.

The pins are oversampled by a faster system clock. Serial clock edges and frame boundaries are found through two-stage synchronisers, so the serial clock must run several times slower than the system clock.

Top module: `swchain_top`

## Requirements
- R1: After reset, `chain_mode` is 0, all eight `sw_en` outputs are 0 (all switches open) and `sdo` is 1.
- R2: In address mode, the value on `sdo` at serial clock rising edges 1 to 8 of a frame is the byte 0x25, most significant bit first (0,0,1,0,0,1,0,1). At rising edges 9 and later it is 0.
- R3: Chain mode is entered at the frame-select rising edge only when the block is in address mode, the frame held exactly 16 serial clock rising edges, and the 16 bits received, first bit as most significant, equal 0x2500. A different word, 15 clocks or 17 clocks leaves the block in address mode.
- R4: In chain mode, the bit sampled on `sdi` at rising edge k is the value of `sdo` at rising edge k+8, counted across frames. `sdo` changes only after a serial clock falling edge or at a frame boundary.
- R5: After chain mode is entered, the first 8 bits that `sdo` presents are 0.
- R6: The 8-bit delay contents are kept while the frame select is high, so the first 8 bits of a frame carry the last 8 bits of the previous frame.
- R7: At each frame-select rising edge in chain mode, the switch data register takes the last 8 bits received, most significant first, with the final bit in bit 0. This holds whatever the clock count was, including counts that are not a multiple of 8 and zero clocks (in which case the bits held from earlier frames are loaded). `sw_en[i]` follows register bit i, so bit 0 drives switch 1.
- R8: In chain mode no frame content, including 0x2500, takes the block out of chain mode. Every frame only targets the switch data register.
- R9: Address-mode frames, including the entry frame itself, leave `sw_en` unchanged.
- R10: `sdo` is 1 while the frame select is high.
- R11: A final serial clock rising edge that arrives at the same moment as the frame-select rising edge is still shifted in and included in the switch load.
- R12: Asserting the hardware reset in chain mode returns the block to address mode, opens all switches and clears the delay contents, so that after re-entry the lead-in bits are 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; data sampled on rising edges |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, updated after falling edges, 1 when idle |
| chain_mode | output | 1 | 1 while the block is in chain mode |
| sw_en | output | 8 | Switch enables; bit 0 controls switch 1 |

## Verification
Two functions can fall into the same sampled cycle: the last serial clock rising edge, which shifts one more bit into the delay line, and the frame-select rising edge, which copies the delay line into the switch register. The bench provokes this by raising the serial clock and the frame select in the same time step on a frame's final bit. It then judges the result by requiring that the switch enables equal the full byte, including that final bit, and that the delay line output at that edge still matches the scoreboard. Other frames keep the two events well apart, so any difference in the result points to the merge itself.

// File: rtl/swchain_pkg.sv
package swchain_pkg;
  localparam int unsigned SW_W  = 8;
  localparam int unsigned CMD_W = 16;
  localparam logic [SW_W-1:0]  ALIGN_BYTE = 8'h25;
  localparam logic [CMD_W-1:0] ENTER_WORD = 16'h2500;

  typedef enum logic {
    LINK_ADDR  = 1'b0,
    LINK_CHAIN = 1'b1
  } link_mode_e;
endpackage

// File: rtl/swchain_pin_sync.sv
module swchain_pin_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] st_q;
    logic [STAGES-1:0] st_d;

    if (STAGES == 1) begin : g_one
      assign st_d = pin_i[b];
    end else begin : g_many
      assign st_d = {st_q[STAGES-2:0], pin_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {STAGES{RST_VAL[b]}};
      else        st_q <= st_d;
    end

    assign sync_o[b] = st_q[STAGES-1];
  end
endmodule

// File: rtl/swchain_frame_track.sv
module swchain_frame_track #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sclk_s,
  output logic             cs_fall,
  output logic             cs_rise,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic [CNT_W-1:0] rcnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             cs_n_d;
  logic             sclk_d;
  logic [CNT_W-1:0] rcnt_q;
  logic             in_frame;

  always_comb begin
    in_frame = ~cs_n_d;
    cs_fall  = cs_n_d & ~cs_n_s;
    cs_rise  = ~cs_n_d & cs_n_s;
    rise_evt = in_frame & sclk_s & ~sclk_d;
    fall_evt = in_frame & ~sclk_s & sclk_d & (rcnt_q != '0);
    rcnt_nxt = rcnt_q;
    if (cs_fall) begin
      rcnt_nxt = '0;
    end else if (rise_evt && (rcnt_q != CNT_MAX)) begin
      rcnt_nxt = rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1;
      sclk_d <= 1'b0;
      rcnt_q <= '0;
    end else begin
      cs_n_d <= cs_n_s;
      sclk_d <= sclk_s;
      rcnt_q <= rcnt_nxt;
    end
  end

  // R4
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);
endmodule

// File: rtl/swchain_entry_detect.sv
module swchain_entry_detect
  import swchain_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             cs_rise,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] rcnt_nxt,
  output logic             chain_mode,
  output logic             enter
);
  localparam logic [CNT_W-1:0] FRAME_LEN = CNT_W'(CMD_W);

  link_mode_e       mode_q, mode_nxt;
  logic [CMD_W-1:0] rx_q, rx_nxt;

  always_comb begin
    rx_nxt = rx_q;
    if (rise_evt && (mode_q == LINK_ADDR)) begin
      rx_nxt = {rx_q[CMD_W-2:0], bit_in};
    end
    enter = cs_rise && (mode_q == LINK_ADDR) &&
            (rcnt_nxt == FRAME_LEN) && (rx_nxt == ENTER_WORD);
    mode_nxt = enter ? LINK_CHAIN : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LINK_ADDR;
      rx_q   <= '0;
    end else begin
      mode_q <= mode_nxt;
      rx_q   <= rx_nxt;
    end
  end

  assign chain_mode = (mode_q == LINK_CHAIN);

  // R8
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_mode |=> chain_mode);

  // R3
  entry_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_mode) |-> $past(cs_rise));
endmodule

// File: rtl/swchain_chain_shift.sv
module swchain_chain_shift
  import swchain_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_evt,
  input  logic            cs_rise,
  input  logic            bit_in,
  input  logic            chain_mode,
  input  logic            enter,
  output logic            chain_msb,
  output logic [SW_W-1:0] sw_o
);
  logic [SW_W-1:0] sh_q, sh_nxt;
  logic [SW_W-1:0] sw_q, sw_nxt;
  logic            sh_en, sw_en_ld;

  always_comb begin
    sh_en  = enter | (rise_evt & chain_mode);
    sh_nxt = sh_q;
    if (enter) begin
      sh_nxt = '0;
    end else if (rise_evt && chain_mode) begin
      sh_nxt = {sh_q[SW_W-2:0], bit_in};
    end
    sw_en_ld = cs_rise & chain_mode;
    sw_nxt   = sw_en_ld ? sh_nxt : sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sw_q <= '0;
    end else begin
      if (sh_en)    sh_q <= sh_nxt;
      if (sw_en_ld) sw_q <= sw_nxt;
    end
  end

  assign chain_msb = sh_q[SW_W-1];
  assign sw_o      = sw_q;

  // R5
  cleared_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_mode) |-> (sh_q == '0));

  // R9
  switch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_rise && chain_mode) |=> $stable(sw_q));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && chain_mode) |=> (sh_q[SW_W-1:1] == $past(sh_q[SW_W-2:0])));

  // R6
  history_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && !rise_evt) |=> $stable(sh_q));
endmodule

// File: rtl/swchain_sdo_drive.sv
module swchain_sdo_drive
  import swchain_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             fall_evt,
  input  logic             chain_mode,
  input  logic             chain_msb,
  input  logic [CNT_W-1:0] rcnt_nxt,
  output logic             sdo
);
  localparam int unsigned IDX_W = $clog2(SW_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SW_W - 1);

  logic             sdo_q, sdo_nxt;
  logic             upd;
  logic             align_bit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx       = TOP_IDX - rcnt_nxt[IDX_W-1:0];
    align_bit = (rcnt_nxt < CNT_W'(SW_W)) ? ALIGN_BYTE[idx] : 1'b0;
    upd       = cs_rise | cs_fall | fall_evt;
    if (cs_rise)         sdo_nxt = 1'b1;
    else if (chain_mode) sdo_nxt = chain_msb;
    else                 sdo_nxt = align_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sdo_q <= 1'b1;
    else if (upd) sdo_q <= sdo_nxt;
  end

  assign sdo = sdo_q;

  // R10
  sdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> sdo_q);

  // R4
  sdo_only_on_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_rise || cs_fall || fall_evt) |=> $stable(sdo_q));
endmodule

// File: rtl/swchain_top.sv
module swchain_top
  import swchain_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(CMD_W + 2) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  output logic            sdo,
  output logic            chain_mode,
  output logic [SW_W-1:0] sw_en
);
  logic [1:0]       rst_q;
  logic             rst_i_n;
  logic [2:0]       pins_s;
  logic             cs_fall, cs_rise, rise_evt, fall_evt, enter, chain_msb;
  logic [CNT_W-1:0] rcnt_nxt;
  logic [SW_W-1:0]  sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  swchain_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .pin_i({cs_n, sclk, sdi}), .sync_o(pins_s)
  );

  swchain_frame_track #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_i_n), .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .rcnt_nxt(rcnt_nxt)
  );

  swchain_entry_detect #(.CNT_W(CNT_W)) u_entry (
    .clk(clk), .rst_n(rst_i_n), .rise_evt(rise_evt), .cs_rise(cs_rise),
    .bit_in(pins_s[0]), .rcnt_nxt(rcnt_nxt), .chain_mode(chain_mode),
    .enter(enter)
  );

  swchain_chain_shift u_shift (
    .clk(clk), .rst_n(rst_i_n), .rise_evt(rise_evt), .cs_rise(cs_rise),
    .bit_in(pins_s[0]), .chain_mode(chain_mode), .enter(enter),
    .chain_msb(chain_msb), .sw_o(sw_q)
  );

  swchain_sdo_drive #(.CNT_W(CNT_W)) u_sdo (
    .clk(clk), .rst_n(rst_i_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .fall_evt(fall_evt), .chain_mode(chain_mode), .chain_msb(chain_msb),
    .rcnt_nxt(rcnt_nxt), .sdo(sdo)
  );

  // R7: register bit i drives switch i+1
  for (genvar i = 0; i < SW_W; i++) begin : g_sw
    assign sw_en[i] = sw_q[i];
  end
endmodule

// File: tb/tb_swchain_top.sv
module tb_swchain_top;
  localparam int HALF = 8;
  localparam logic [7:0] ALIGN = 8'h25;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  logic sdo, chain_mode;
  logic [7:0] sw_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit in_frame = 0;

  logic  exp_q[$];
  string tag_q[$];

  logic       m_chain;
  logic [7:0] m_sh, m_sw;
  int         m_since;

  always #5 clk = ~clk;

  swchain_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .chain_mode(chain_mode), .sw_en(sw_en)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares sdo at each serial rising edge with the scoreboard
  always @(posedge sclk) begin
    if (in_frame) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected serial edge", 16'd1, 16'd0);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {15'd0, sdo}, {15'd0, e});
      end
    end
  end

  task automatic send(input logic [31:0] word, input int n, input bit coincide,
                      input string ftag);
    @(negedge clk);
    cs_n = 1'b0;
    in_frame = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      int k;
      k = n - 1 - i;
      sdi = word[i];
      if (m_chain) begin
        exp_q.push_back(m_sh[7]);
        tag_q.push_back({(m_since < 8) ? "R5 lead-in zero " : "R4 delay ", ftag});
        m_sh = {m_sh[6:0], word[i]};
        m_since++;
      end else begin
        exp_q.push_back((k < 8) ? ALIGN[7 - k] : 1'b0);
        tag_q.push_back({"R2 alignment echo ", ftag});
      end
      repeat (HALF) @(negedge clk);
      if (coincide && i == 0) begin
        sclk = 1'b1;
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end else begin
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
    end
    if (!(coincide && n > 0)) begin
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
    end
    in_frame = 1'b0;
    if (m_chain) begin
      m_sw = m_sh;
    end else if (n == 16 && word[15:0] == 16'h2500) begin
      m_chain = 1'b1;
      m_sh = 8'h00;
      m_since = 0;
    end
    repeat (8) @(negedge clk);
    chk({"R7 R9 switch register ", ftag}, {8'd0, sw_en}, {8'd0, m_sw});
    chk({"R3 R8 mode flag ", ftag}, {15'd0, chain_mode}, {15'd0, m_chain});
    chk({"R10 idle sdo ", ftag}, {15'd0, sdo}, 16'd1);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    m_chain = 1'b0;
    m_sh = 8'h00;
    m_sw = 8'h00;
    m_since = 0;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    m_chain = 1'b0; m_sh = 8'h00; m_sw = 8'h00; m_since = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 reset mode", {15'd0, chain_mode}, 16'd0);
    chk("R1 reset switches", {8'd0, sw_en}, 16'd0);
    chk("R1 reset sdo", {15'd0, sdo}, 16'd1);

    send(32'h2501, 16, 0, "R3 wrong word");
    send(32'h12500, 17, 0, "R3 seventeen clocks");
    send(32'h1280, 15, 0, "R3 fifteen clocks");
    send(32'h2500, 16, 0, "R3 R9 entry");
    send(32'hA5, 8, 0, "R5 first chain frame");
    send(32'h3C96, 16, 0, "R6 history carried");
    send(32'hAB7, 12, 0, "R7 twelve clocks");
    send(32'h0, 0, 0, "R7 zero clocks");
    send(32'h2500, 16, 0, "R8 entry word as data");
    send(32'h5A, 8, 1, "R11 coincident edge");
    send(32'h01, 8, 0, "R7 bit0 drives switch 1");
    chk("R7 switch 1 on", {15'd0, sw_en[0]}, 16'd1);
    chk("R7 switch 8 off", {15'd0, sw_en[7]}, 16'd0);

    hw_reset();
    chk("R12 reset leaves chain", {15'd0, chain_mode}, 16'd0);
    chk("R12 reset opens switches", {8'd0, sw_en}, 16'd0);
    send(32'h2500, 16, 0, "R12 re-entry");
    send(32'hFF, 8, 0, "R12 cleared history");

    chk("R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 16'd0, 16'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule